// File: doc/BRIEF.md
# Clock Time-Setting Controller with Auto-Repeat

This block is the user-interface front end for setting a digital clock. It takes three debounced push buttons (mode, select and increment) and a 4 Hz tick enable. From them it keeps a three-state mode register and a record of which field, hours or minutes, is being adjusted. It drives two indicator LEDs and produces single-cycle increment enables for the hour and minute counters of either the current time or the alarm time. The BCD counters themselves sit outside the block.

A short press of increment gives exactly one step. Holding the button for a set number of ticks switches to auto-repeat, with one step per tick until the button is released. In run mode, holding select for a set number of ticks raises a seconds-clear level, which lets the time be matched to a reference. Every output is a plain enable or level in the system clock domain. Ticks are enables, not derived clocks.

Top module: `clock_set_ctrl`

## Requirements
- R1: After reset, mode_o is 0, both LEDs are off, all four increment outputs are low and clear_sec_o is low.
- R2: Each press (synchronised rising edge) of mode_btn_i advances mode_o 0 → 1 → 2 → 0. The encoding is 0 = run, 1 = alarm set, 2 = time set, and 3 never appears.
- R3: Reset selects hours. Each press of sel_btn_i in mode 1 or 2 toggles the selected field. A press in mode 0 leaves the selection unchanged.
- R4: In modes 1 and 2, led_hour_o is high when hours are selected and led_min_o is high when minutes are selected, never both. In mode 0 both LEDs are off.
- R5: A press of inc_btn_i in mode 2 gives one single-cycle pulse on inc_hour_time_o or inc_min_time_o, according to the selected field. In mode 1 it gives the pulse on inc_hour_alarm_o or inc_min_alarm_o instead.
- R6: Presses and holds of inc_btn_i in mode 0 produce no increment pulse.
- R7: While inc_btn_i is held, the first HOLD_TICKS ticks (default 4) produce no further pulses. Every tick after that produces one pulse on the selected output, until the button is released.
- R8: Releasing inc_btn_i clears the hold count. After a new press, a full HOLD_TICKS ticks must pass again before auto-repeat starts.
- R9: In mode 0, clear_sec_o goes high once sel_btn_i has been held for CLEAR_TICKS ticks (default 4). It stays high while the button is held and drops on release. In modes 1 and 2 it stays low.
- R10: At most one of the four increment outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 4 Hz single-cycle tick enable |
| mode_btn_i | input | 1 | Debounced mode button, high when pressed |
| sel_btn_i | input | 1 | Debounced field-select button |
| inc_btn_i | input | 1 | Debounced increment button |
| mode_o | output | 2 | Current mode: 0 run, 1 alarm set, 2 time set |
| led_hour_o | output | 1 | Hours field selected indicator |
| led_min_o | output | 1 | Minutes field selected indicator |
| inc_hour_time_o | output | 1 | Increment enable for the time hours counter |
| inc_min_time_o | output | 1 | Increment enable for the time minutes counter |
| inc_hour_alarm_o | output | 1 | Increment enable for the alarm hours counter |
| inc_min_alarm_o | output | 1 | Increment enable for the alarm minutes counter |
| clear_sec_o | output | 1 | Seconds-clear request level |

## Verification
The hardest case to reach is the exact boundary of auto-repeat. A tick that arrives while the hold count is one short must give no pulse, and the next tick must give one. After a release and a new press, the count must start again from zero. The bench owns tick_i and issues each tick by hand once the button level has passed the synchroniser. Because of this, the number of ticks seen while held is known exactly, and an expected pulse is queued just before the one tick that should produce it. Whenever any increment output is high, the scoreboard pops an item, so a doubled pulse, a pulse one tick early or a pulse on the wrong field shows up as a mismatch.

// File: rtl/clkset_pkg.sv
package clkset_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_ALARM = 2'd1,
    MODE_TIME  = 2'd2
  } mode_e;
endpackage

// File: rtl/clkset_btn_sync.sv
module clkset_btn_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] btn_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o
);
  for (genvar b = 0; b < N; b++) begin : g_btn
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q <= '0;
        prev_q <= 1'b0;
      end else begin
        sync_q <= {sync_q[STAGES-2:0], btn_i[b]};
        prev_q <= sync_q[STAGES-1];
      end
    end
    assign level_o[b] = sync_q[STAGES-1];
    assign rise_o[b]  = sync_q[STAGES-1] & ~prev_q;
  end
endmodule

// File: rtl/clkset_hold_timer.sv
module clkset_hold_timer #(
  parameter int unsigned LIMIT = 4,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic level_i,
  output logic reached_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (!level_i)                       cnt_q <= '0;
    else if (tick_i && cnt_q != CW'(LIMIT))  cnt_q <= cnt_q + 1'b1;
  end

  assign reached_o = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/clkset_mode.sv
module clkset_mode
  import clkset_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  mode_rise_i,
  input  logic  sel_rise_i,
  output mode_e mode_o,
  output logic  sel_hour_o
);
  mode_e mode_q;
  logic  sel_hour_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_RUN;
      sel_hour_q <= 1'b1;
    end else begin
      if (mode_rise_i) begin
        unique case (mode_q)
          MODE_RUN:   mode_q <= MODE_ALARM;
          MODE_ALARM: mode_q <= MODE_TIME;
          default:    mode_q <= MODE_RUN;
        endcase
      end
      if (sel_rise_i && mode_q != MODE_RUN) sel_hour_q <= ~sel_hour_q;
    end
  end

  assign mode_o     = mode_q;
  assign sel_hour_o = sel_hour_q;
endmodule

// File: rtl/clock_set_ctrl.sv
module clock_set_ctrl
  import clkset_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_TICKS  = 4,
  parameter int unsigned CLEAR_TICKS = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       mode_btn_i,
  input  logic       sel_btn_i,
  input  logic       inc_btn_i,
  output logic [1:0] mode_o,
  output logic       led_hour_o,
  output logic       led_min_o,
  output logic       inc_hour_time_o,
  output logic       inc_min_time_o,
  output logic       inc_hour_alarm_o,
  output logic       inc_min_alarm_o,
  output logic       clear_sec_o
);
  localparam int unsigned NBTN = 3;
  localparam int unsigned B_MODE = 0;
  localparam int unsigned B_SEL  = 1;
  localparam int unsigned B_INC  = 2;

  logic [NBTN-1:0] level, rise;
  mode_e mode;
  logic  sel_hour, inc_rep, sel_long, pulse_q;

  clkset_btn_sync #(.N(NBTN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .btn_i   ({inc_btn_i, sel_btn_i, mode_btn_i}),
    .level_o (level),
    .rise_o  (rise)
  );

  clkset_mode u_mode (
    .clk_i, .rst_ni,
    .mode_rise_i (rise[B_MODE]),
    .sel_rise_i  (rise[B_SEL]),
    .mode_o      (mode),
    .sel_hour_o  (sel_hour)
  );

  clkset_hold_timer #(.LIMIT(HOLD_TICKS)) u_inc_hold (
    .clk_i, .rst_ni, .tick_i,
    .level_i   (level[B_INC]),
    .reached_o (inc_rep)
  );

  clkset_hold_timer #(.LIMIT(CLEAR_TICKS)) u_sel_hold (
    .clk_i, .rst_ni, .tick_i,
    .level_i   (level[B_SEL]),
    .reached_o (sel_long)
  );

  // raw step request: press edge, or a tick once repeat is armed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= rise[B_INC] | (tick_i & level[B_INC] & inc_rep);
  end

  // routing uses the current mode so a step never lands in a stale mode
  assign inc_hour_time_o  = pulse_q & (mode == MODE_TIME)  &  sel_hour;
  assign inc_min_time_o   = pulse_q & (mode == MODE_TIME)  & ~sel_hour;
  assign inc_hour_alarm_o = pulse_q & (mode == MODE_ALARM) &  sel_hour;
  assign inc_min_alarm_o  = pulse_q & (mode == MODE_ALARM) & ~sel_hour;

  assign led_hour_o  = (mode != MODE_RUN) &  sel_hour;
  assign led_min_o   = (mode != MODE_RUN) & ~sel_hour;
  assign clear_sec_o = (mode == MODE_RUN) & sel_long & level[B_SEL];
  assign mode_o      = mode;
endmodule

// File: rtl/clkset_chk.sv
module clkset_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_o,
  input logic       led_hour_o,
  input logic       led_min_o,
  input logic       inc_hour_time_o,
  input logic       inc_min_time_o,
  input logic       inc_hour_alarm_o,
  input logic       inc_min_alarm_o,
  input logic       clear_sec_o
);
  // R2
  mode_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'd3);

  // R2
  mode_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_o) |-> mode_o == (($past(mode_o) == 2'd2) ? 2'd0 : $past(mode_o) + 2'd1));

  // R4
  led_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 2'd0) |-> (led_hour_o ^ led_min_o));

  // R4
  led_run_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0) |-> !(led_hour_o || led_min_o));

  // R5
  time_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_hour_time_o || inc_min_time_o) |-> mode_o == 2'd2);

  // R5
  alarm_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_hour_alarm_o || inc_min_alarm_o) |-> mode_o == 2'd1);

  // R10
  one_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({inc_hour_time_o, inc_min_time_o, inc_hour_alarm_o, inc_min_alarm_o}));

  // R9
  clear_run_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_sec_o |-> mode_o == 2'd0);
endmodule

bind clock_set_ctrl clkset_chk chk_i (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .mode_o           (mode_o),
  .led_hour_o       (led_hour_o),
  .led_min_o        (led_min_o),
  .inc_hour_time_o  (inc_hour_time_o),
  .inc_min_time_o   (inc_min_time_o),
  .inc_hour_alarm_o (inc_hour_alarm_o),
  .inc_min_alarm_o  (inc_min_alarm_o),
  .clear_sec_o      (clear_sec_o)
);

// File: tb/clock_set_ctrl_tb_top.sv
`timescale 1ns/1ps
module clock_set_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, mode_b = 1'b0, sel_b = 1'b0, inc_b = 1'b0;
  logic [1:0] mode;
  logic led_h, led_m, iht, imt, iha, ima, clr;

  int checks = 0, errors = 0, seen = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  localparam logic [3:0] C_TH = 4'b1000, C_TM = 4'b0100, C_AH = 4'b0010, C_AM = 4'b0001;

  always #5 clk = ~clk;

  clock_set_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .mode_btn_i(mode_b), .sel_btn_i(sel_b), .inc_btn_i(inc_b),
    .mode_o(mode), .led_hour_o(led_h), .led_min_o(led_m),
    .inc_hour_time_o(iht), .inc_min_time_o(imt),
    .inc_hour_alarm_o(iha), .inc_min_alarm_o(ima),
    .clear_sec_o(clr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: every increment cycle pops one expected item
  always @(negedge clk) begin
    if (rst_n && {iht, imt, iha, ima} != 4'b0) begin
      seen++;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R6/R7/R10 unexpected pulse: actual=%0d expected=0", {iht, imt, iha, ima});
      end else begin
        automatic logic [3:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if ({iht, imt, iha, ima} != e) begin
          errors++;
          $display("FAIL %s: actual=%0d expected=%0d", t, {iht, imt, iha, ima}, e);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_inc(input logic [3:0] c, input string t);
    exp_q.push_back(c);
    tag_q.push_back(t);
  endtask

  task automatic do_tick();
    tick = 1'b1; cyc(1); tick = 1'b0; cyc(5);
  endtask

  task automatic press_mode();
    mode_b = 1'b1; cyc(8); mode_b = 1'b0; cyc(8);
  endtask

  task automatic press_sel();
    sel_b = 1'b1; cyc(8); sel_b = 1'b0; cyc(8);
  endtask

  task automatic press_inc(input logic [3:0] c, input string t);
    if (c != 4'b0) expect_inc(c, t);
    inc_b = 1'b1; cyc(8); inc_b = 1'b0; cyc(8);
  endtask

  bit done = 0;
  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int s0;
    cyc(3);
    // R1 reset state
    check(mode == 2'd0, "R1 mode", mode, 0);
    check(!led_h && !led_m, "R1 leds", {led_h, led_m}, 0);
    check({iht, imt, iha, ima} == 4'b0, "R1 inc", {iht, imt, iha, ima}, 0);
    check(!clr, "R1 clear", clr, 0);
    rst_n = 1'b1; cyc(3);

    // R6: increment ignored in run mode, including a long hold
    s0 = seen;
    press_inc(4'b0, "R6");
    inc_b = 1'b1; cyc(8);
    for (int i = 0; i < 6; i++) do_tick();
    inc_b = 1'b0; cyc(8);
    check(seen == s0, "R6 no pulse in mode 0", seen - s0, 0);

    // R3: select in mode 0 keeps hours selected
    press_sel();
    press_mode();
    check(mode == 2'd1, "R2 run->alarm", mode, 1);
    check(led_h && !led_m, "R3 sel unchanged by mode 0 press", {led_h, led_m}, 2);

    press_inc(C_AH, "R5 alarm hour");
    press_sel();
    check(!led_h && led_m, "R4 minutes led", {led_h, led_m}, 1);
    press_inc(C_AM, "R5 alarm min");

    press_mode();
    check(mode == 2'd2, "R2 alarm->time", mode, 2);
    check(led_m && !led_h, "R4 selection kept across mode", {led_h, led_m}, 1);
    press_inc(C_TM, "R5 time min");
    press_sel();
    check(led_h && !led_m, "R3 toggle in mode 2", {led_h, led_m}, 2);
    press_inc(C_TH, "R5 time hour");

    // R7: auto-repeat boundary
    s0 = seen;
    expect_inc(C_TH, "R7 press step");
    inc_b = 1'b1; cyc(8);
    for (int i = 0; i < 4; i++) do_tick();
    check(seen - s0 == 1, "R7 no repeat within hold ticks", seen - s0, 1);
    for (int i = 0; i < 3; i++) begin
      expect_inc(C_TH, "R7 repeat step");
      do_tick();
    end
    check(seen - s0 == 4, "R7 one step per tick", seen - s0, 4);
    inc_b = 1'b0; cyc(8);
    do_tick();
    check(seen - s0 == 4, "R7 stops on release", seen - s0, 4);

    // R8: hold count restarts after release
    s0 = seen;
    expect_inc(C_TH, "R8 re-press step");
    inc_b = 1'b1; cyc(8);
    for (int i = 0; i < 4; i++) do_tick();
    check(seen - s0 == 1, "R8 count restarted", seen - s0, 1);
    expect_inc(C_TH, "R8 repeat after full hold");
    do_tick();
    check(seen - s0 == 2, "R8 repeat resumes", seen - s0, 2);
    inc_b = 1'b0; cyc(8);

    // R9: seconds clear in run mode
    press_mode();
    check(mode == 2'd0, "R2 time->run wrap", mode, 0);
    check(!led_h && !led_m, "R4 leds off in mode 0", {led_h, led_m}, 0);
    sel_b = 1'b1; cyc(8);
    for (int i = 0; i < 3; i++) do_tick();
    check(!clr, "R9 clear not before hold", clr, 0);
    do_tick();
    check(clr, "R9 clear after hold", clr, 1);
    cyc(20);
    check(clr, "R9 clear stays while held", clr, 1);
    sel_b = 1'b0; cyc(8);
    check(!clr, "R9 clear drops on release", clr, 0);

    press_mode();
    check(led_h && !led_m, "R3 long select in mode 0 no toggle", {led_h, led_m}, 2);
    press_mode();
    sel_b = 1'b1; cyc(8);
    for (int i = 0; i < 6; i++) do_tick();
    check(!clr, "R9 no clear in mode 2", clr, 0);
    sel_b = 1'b0; cyc(8);
    check(led_m && !led_h, "R3 one toggle per press", {led_h, led_m}, 1);

    cyc(10);
    check(exp_q.size() == 0, "R5/R7 all expected pulses seen", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule